// File: doc/BRIEF.md
# Coprocessor Host Mailbox and Firmware Loader

This block sits between a host CPU on a pipelined Wishbone bus and a small embedded stack-processor coprocessor. It gives the two processors a pair of crossed one-byte channels that both sides use like UART data registers. A byte the host transmits becomes the byte the coprocessor receives, and the reverse path works the same way.

The same slave port opens a window onto the coprocessor's program memory, so the host can install firmware. A control bit keeps the coprocessor in reset until the host clears it. A constant signature word at the very top of the address space lets software confirm which module occupies the slot before it touches anything else.

The coprocessor side is a plain strobe-and-data register interface. It has a byte push, a byte pop and a synchronous program-memory read port. The program memory depth is set by `IMEM_AW`. The system instance uses `IMEM_AW = 13` (8192 words, 32 KiB). The default of 11 (2048 words) keeps stand-alone builds small.

Top module: `cop_mailbox`

## Requirements
- R1: After reset, `cop_rst_o` is 1, `cop_rx_valid_o` is 0, `cop_tx_ready_o` is 1, ack and err are low, and a read of the status word (word address 0x10002) returns 0x2.
- R2: A host write to word 0x10000 latches data bits 7:0 into the host-to-coprocessor holding register. On the cycle after the ack, that byte appears on `cop_rx_data_o` with `cop_rx_valid_o` high. A one-cycle `cop_rx_pop_i` empties the register.
- R3: A byte pushed with `cop_tx_valid_i` while `cop_tx_ready_o` is high is returned in bits 7:0 of a host read of word 0x10001. That read empties the channel.
- R4: A host read of word 0x10001 while that channel is empty returns 0 with ack and without err.
- R5: A host write to word 0x10000 while the channel is full is dropped and answered with err. A coprocessor push while its channel is full is dropped. In both cases the first byte is the one delivered.
- R6: Status word 0x10002 reads bit 0 = host receive data available and bit 1 = host transmit ready. All other bits read 0.
- R7: Words 0 to 2**IMEM_AW-1 map to program memory. Host writes honour byte selects (`wb_sel_i[k]` covers bits 8k+7:8k). Host reads return the stored word with the ack. The coprocessor read port returns the word on the cycle after `cop_imem_en_i`.
- R8: Control word 0x10003 bit 0 is the reset hold. It reads back, resets to 1, and drives `cop_rst_o`. `cop_rst_o` falls only after a host write of 0 to this word.
- R9: Word 0x3FFFF reads 0xF041011B. A write to it is answered with err and leaves the value unchanged.
- R10: Unmapped words are answered with err and read data 0. These are words from 2**IMEM_AW up to 0xFFFF, 0x10004 to 0x3FFFE, a write to 0x10001 or 0x10002, and a read of 0x10000.
- R11: When `cop_imem_en_i` is high in the same cycle as a host program-memory access, the coprocessor read is served and the host is stalled. The host access completes once the coprocessor port is idle.
- R12: Every accepted request gets exactly one response, ack or err, on the next cycle. Ack and err are never high together, and stall is only raised for the collision of R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 18 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte selects |
| wb_stall_o | output | 1 | Request not accepted this cycle |
| wb_ack_o | output | 1 | Normal response |
| wb_err_o | output | 1 | Error response |
| wb_dat_o | output | 32 | Read data |
| cop_rst_o | output | 1 | Holds the coprocessor in reset |
| cop_rx_data_o | output | 8 | Byte for the coprocessor |
| cop_rx_valid_o | output | 1 | Byte for the coprocessor is waiting |
| cop_rx_pop_i | input | 1 | Coprocessor consumes its byte |
| cop_tx_data_i | input | 8 | Byte from the coprocessor |
| cop_tx_valid_i | input | 1 | Coprocessor pushes its byte |
| cop_tx_ready_o | output | 1 | Coprocessor channel can take a byte |
| cop_imem_en_i | input | 1 | Coprocessor program read request |
| cop_imem_addr_i | input | IMEM_AW | Coprocessor program word address |
| cop_imem_data_o | output | 32 | Program word, one cycle after request |

## Verification
A holding register whose valid flag is wrong becomes visible within one cycle, in two ways. The status word or the coprocessor-side valid and ready pins disagree with the traffic so far. A lost or repeated byte then appears at the next receive read. A fault in the memory arbitration shows up on the collision cycle as a missing stall or a coprocessor word overwritten by host data. A write that slipped through anyway is revealed by the later host read-back. Decode faults surface immediately as ack in place of err, or as nonzero data from holes in the map.

// File: rtl/cmb_pkg.sv
`timescale 1ns/1ps
package cmb_pkg;
  localparam int WB_AW = 18;
  localparam int WB_DW = 32;
  localparam int CH_W  = 8;

  localparam logic [WB_AW-1:0] OFS_TXD  = 18'h10000;
  localparam logic [WB_AW-1:0] OFS_RXD  = 18'h10001;
  localparam logic [WB_AW-1:0] OFS_STAT = 18'h10002;
  localparam logic [WB_AW-1:0] OFS_CTRL = 18'h10003;
  localparam logic [WB_AW-1:0] OFS_SIG  = 18'h3FFFF;

  localparam logic [WB_DW-1:0] SIGNATURE = 32'hF041011B;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_MEM, TGT_TXD, TGT_RXD, TGT_STAT, TGT_CTRL, TGT_SIG
  } tgt_e;
endpackage

// File: rtl/cmb_decode.sv
`timescale 1ns/1ps
module cmb_decode import cmb_pkg::*; #(
  parameter int IMEM_AW = 11
) (
  input  logic [WB_AW-1:0] adr_i,
  output tgt_e             tgt_o
);
  localparam int HI_W = WB_AW - IMEM_AW;

  logic in_mem;
  assign in_mem = (adr_i[WB_AW-1:IMEM_AW] == {HI_W{1'b0}});

  always_comb begin
    tgt_o = TGT_NONE;
    if (in_mem)                 tgt_o = TGT_MEM;
    else if (adr_i == OFS_TXD)  tgt_o = TGT_TXD;
    else if (adr_i == OFS_RXD)  tgt_o = TGT_RXD;
    else if (adr_i == OFS_STAT) tgt_o = TGT_STAT;
    else if (adr_i == OFS_CTRL) tgt_o = TGT_CTRL;
    else if (adr_i == OFS_SIG)  tgt_o = TGT_SIG;
  end
endmodule

// File: rtl/cmb_chan.sv
`timescale 1ns/1ps
module cmb_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  // push only lands in an empty slot; a pop of a full slot empties it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/cmb_imem.sv
`timescale 1ns/1ps
module cmb_imem #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            host_req_i,
  input  logic            host_we_i,
  input  logic [DW/8-1:0] host_sel_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  input  logic            cop_en_i,
  input  logic [AW-1:0]   cop_addr_i,
  output logic [DW-1:0]   rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int NB    = DW / 8;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [AW-1:0] addr;
  logic          wr, rd;

  // single port: coprocessor wins, host side is stalled at the bus
  assign addr = cop_en_i ? cop_addr_i : host_addr_i;
  assign wr   = host_req_i && host_we_i && !cop_en_i;
  assign rd   = cop_en_i || (host_req_i && !host_we_i);

  always_ff @(posedge clk_i) begin
    if (wr) begin
      for (int b = 0; b < NB; b++)
        if (host_sel_i[b]) mem[addr][8*b +: 8] <= host_wdata_i[8*b +: 8];
    end
    if (rd) rdata_q <= mem[addr];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cop_mailbox.sv
`timescale 1ns/1ps
module cop_mailbox import cmb_pkg::*; #(
  parameter int IMEM_AW = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [17:0]        wb_adr_i,
  input  logic [31:0]        wb_dat_i,
  input  logic [3:0]         wb_sel_i,
  output logic               wb_stall_o,
  output logic               wb_ack_o,
  output logic               wb_err_o,
  output logic [31:0]        wb_dat_o,
  output logic               cop_rst_o,
  output logic [7:0]         cop_rx_data_o,
  output logic               cop_rx_valid_o,
  input  logic               cop_rx_pop_i,
  input  logic [7:0]         cop_tx_data_i,
  input  logic               cop_tx_valid_i,
  output logic               cop_tx_ready_o,
  input  logic               cop_imem_en_i,
  input  logic [IMEM_AW-1:0] cop_imem_addr_i,
  output logic [31:0]        cop_imem_data_o
);
  tgt_e            tgt;
  logic            req, accept, err_cond;
  logic            h2c_full, c2h_full;
  logic [CH_W-1:0] h2c_data, c2h_data;
  logic            h2c_push, c2h_pop;
  logic            hold_q, ack_q, err_q, rd_mem_q;
  logic [WB_DW-1:0] dat_q, rd_val, mem_rdata;

  cmb_decode #(.IMEM_AW(IMEM_AW)) u_dec (.adr_i(wb_adr_i), .tgt_o(tgt));

  assign req        = wb_cyc_i && wb_stb_i;
  assign wb_stall_o = req && (tgt == TGT_MEM) && cop_imem_en_i;
  assign accept     = req && !wb_stall_o;

  always_comb begin
    unique case (tgt)
      TGT_MEM:  err_cond = 1'b0;
      TGT_TXD:  err_cond = !wb_we_i || h2c_full;
      TGT_RXD:  err_cond = wb_we_i;
      TGT_STAT: err_cond = wb_we_i;
      TGT_CTRL: err_cond = 1'b0;
      TGT_SIG:  err_cond = wb_we_i;
      default:  err_cond = 1'b1;
    endcase
  end

  assign h2c_push = accept && wb_we_i && (tgt == TGT_TXD);
  assign c2h_pop  = accept && !wb_we_i && (tgt == TGT_RXD);

  cmb_chan #(.W(CH_W)) u_h2c (
    .clk_i, .rst_ni,
    .push_i(h2c_push), .data_i(wb_dat_i[CH_W-1:0]), .pop_i(cop_rx_pop_i),
    .full_o(h2c_full), .data_o(h2c_data)
  );

  cmb_chan #(.W(CH_W)) u_c2h (
    .clk_i, .rst_ni,
    .push_i(cop_tx_valid_i), .data_i(cop_tx_data_i), .pop_i(c2h_pop),
    .full_o(c2h_full), .data_o(c2h_data)
  );

  cmb_imem #(.AW(IMEM_AW), .DW(WB_DW)) u_imem (
    .clk_i,
    .host_req_i(req && (tgt == TGT_MEM)),
    .host_we_i(wb_we_i),
    .host_sel_i(wb_sel_i),
    .host_addr_i(wb_adr_i[IMEM_AW-1:0]),
    .host_wdata_i(wb_dat_i),
    .cop_en_i(cop_imem_en_i),
    .cop_addr_i(cop_imem_addr_i),
    .rdata_o(mem_rdata)
  );

  always_comb begin
    unique case (tgt)
      TGT_RXD:  rd_val = c2h_full ? {{(WB_DW-CH_W){1'b0}}, c2h_data} : '0;
      TGT_STAT: rd_val = {{(WB_DW-2){1'b0}}, !h2c_full, c2h_full};
      TGT_CTRL: rd_val = {{(WB_DW-1){1'b0}}, hold_q};
      TGT_SIG:  rd_val = SIGNATURE;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b1;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
      rd_mem_q <= 1'b0;
      dat_q    <= '0;
    end else begin
      ack_q    <= accept && !err_cond;
      err_q    <= accept && err_cond;
      rd_mem_q <= accept && !wb_we_i && (tgt == TGT_MEM);
      dat_q    <= (accept && !wb_we_i && !err_cond) ? rd_val : '0;
      if (accept && wb_we_i && (tgt == TGT_CTRL) && wb_sel_i[0])
        hold_q <= wb_dat_i[0];
    end
  end

  assign wb_ack_o        = ack_q;
  assign wb_err_o        = err_q;
  assign wb_dat_o        = rd_mem_q ? mem_rdata : dat_q;
  assign cop_rst_o       = hold_q;
  assign cop_rx_data_o   = h2c_data;
  assign cop_rx_valid_o  = h2c_full;
  assign cop_tx_ready_o  = !c2h_full;
  assign cop_imem_data_o = mem_rdata;
endmodule

// File: rtl/cop_mailbox_chk.sv
`timescale 1ns/1ps
module cop_mailbox_chk import cmb_pkg::*; (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wb_cyc_i,
  input logic        wb_stb_i,
  input logic        wb_we_i,
  input logic [17:0] wb_adr_i,
  input logic        wb_stall_o,
  input logic        wb_ack_o,
  input logic        wb_err_o,
  input logic [31:0] wb_dat_o,
  input logic        cop_rst_o,
  input logic        cop_tx_ready_o,
  input logic        cop_imem_en_i
);
  logic acc;
  assign acc = wb_cyc_i && wb_stb_i && !wb_stall_o;

  assert_ack_err_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_ack_o && wb_err_o));

  assert_resp_follows_accept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o || wb_err_o) |-> $past(acc));

  assert_stall_only_collision_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stall_o |-> cop_imem_en_i);

  assert_signature_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !wb_we_i && wb_adr_i == OFS_SIG) |=> (wb_ack_o && wb_dat_o == SIGNATURE));

  assert_release_by_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cop_rst_o) |-> $past(acc && wb_we_i && wb_adr_i == OFS_CTRL));

  assert_hole_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wb_adr_i == 18'h10004) |=> (wb_err_o && wb_dat_o == 32'h0));

  assert_full_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cop_tx_ready_o && !(acc && !wb_we_i && wb_adr_i == OFS_RXD)) |=> !cop_tx_ready_o);
endmodule

bind cop_mailbox cop_mailbox_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i),
  .wb_stall_o(wb_stall_o), .wb_ack_o(wb_ack_o), .wb_err_o(wb_err_o), .wb_dat_o(wb_dat_o),
  .cop_rst_o(cop_rst_o), .cop_tx_ready_o(cop_tx_ready_o), .cop_imem_en_i(cop_imem_en_i)
);

// File: tb/cop_mailbox_bench.sv
`timescale 1ns/1ps
module cop_mailbox_bench;
  localparam int AW = 11;
  localparam logic [17:0] A_TXD = 18'h10000, A_RXD = 18'h10001, A_STAT = 18'h10002,
                          A_CTRL = 18'h10003, A_SIG = 18'h3FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [17:0] adr = '0;
  logic [31:0] wdat = '0;
  logic [3:0] sel = '0;
  logic stall, ack, err;
  logic [31:0] rdat;
  logic cop_rst, rx_valid, tx_ready;
  logic [7:0] rx_data;
  logic rx_pop = 0, tx_valid = 0;
  logic [7:0] tx_data = '0;
  logic im_en = 0;
  logic [AW-1:0] im_addr = '0;
  logic [31:0] im_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cop_mailbox #(.IMEM_AW(AW)) u_cop_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat),
    .wb_sel_i(sel), .wb_stall_o(stall), .wb_ack_o(ack), .wb_err_o(err), .wb_dat_o(rdat),
    .cop_rst_o(cop_rst), .cop_rx_data_o(rx_data), .cop_rx_valid_o(rx_valid),
    .cop_rx_pop_i(rx_pop), .cop_tx_data_i(tx_data), .cop_tx_valid_i(tx_valid),
    .cop_tx_ready_o(tx_ready), .cop_imem_en_i(im_en), .cop_imem_addr_i(im_addr),
    .cop_imem_data_o(im_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one pipelined access; response sampled just after the accepting edge's successor state
  task automatic wb_op(input logic w, input logic [17:0] a, input logic [31:0] d,
                       input logic [3:0] s, output logic k, output logic e,
                       output logic [31:0] q);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d; sel = s;
    while (stall) @(negedge clk);
    @(posedge clk); #1;
    k = ack; e = err; q = rdat;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
    chk("R12 ack/err exclusive", {31'b0, k & e}, 32'h0);
  endtask

  task automatic rd_ok(input string req, input logic [17:0] a, input logic [31:0] exp);
    logic k, e; logic [31:0] q;
    wb_op(1'b0, a, '0, 4'hF, k, e, q);
    chk({req, " ack"}, {31'b0, k}, 32'h1);
    chk({req, " err"}, {31'b0, e}, 32'h0);
    chk({req, " data"}, q, exp);
  endtask

  task automatic wr_resp(input string req, input logic [17:0] a, input logic [31:0] d,
                         input logic [3:0] s, input logic exp_err);
    logic k, e; logic [31:0] q;
    wb_op(1'b1, a, d, s, k, e, q);
    chk({req, " ack"}, {31'b0, k}, {31'b0, !exp_err});
    chk({req, " err"}, {31'b0, e}, {31'b0, exp_err});
  endtask

  task automatic cop_push(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic cop_pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic t_reset_r1();
    chk("R1 cop_rst", {31'b0, cop_rst}, 32'h1);
    chk("R1 rx_valid", {31'b0, rx_valid}, 32'h0);
    chk("R1 tx_ready", {31'b0, tx_ready}, 32'h1);
    chk("R1 ack/err", {30'b0, ack, err}, 32'h0);
    rd_ok("R1 status", A_STAT, 32'h2);
  endtask

  task automatic t_host_to_cop_r2();
    wr_resp("R2 tx write", A_TXD, 32'hFFFF_FFA5, 4'hF, 1'b0);
    chk("R2 cop rx valid", {31'b0, rx_valid}, 32'h1);
    chk("R2 cop rx data", {24'b0, rx_data}, 32'hA5);
    rd_ok("R6 status tx busy", A_STAT, 32'h0);
    cop_pop();
    chk("R2 pop clears", {31'b0, rx_valid}, 32'h0);
    rd_ok("R6 status idle", A_STAT, 32'h2);
  endtask

  task automatic t_cop_to_host_r3();
    cop_push(8'h3C);
    chk("R3 cop tx ready low", {31'b0, tx_ready}, 32'h0);
    rd_ok("R6 status both", A_STAT, 32'h3);
    rd_ok("R3 host rx", A_RXD, 32'h3C);
    chk("R3 read frees", {31'b0, tx_ready}, 32'h1);
    rd_ok("R4 empty rx", A_RXD, 32'h0);
  endtask

  task automatic t_full_r5();
    wr_resp("R5 first tx", A_TXD, 32'h11, 4'hF, 1'b0);
    wr_resp("R5 tx while full", A_TXD, 32'h22, 4'hF, 1'b1);
    chk("R5 first byte kept", {24'b0, rx_data}, 32'h11);
    cop_pop();
    cop_push(8'h44);
    cop_push(8'h55);
    rd_ok("R5 cop first byte kept", A_RXD, 32'h44);
    rd_ok("R5 second byte dropped", A_RXD, 32'h0);
  endtask

  task automatic t_mem_r7();
    wr_resp("R7 wr w0", 18'h0, 32'h1234_5678, 4'hF, 1'b0);
    wr_resp("R7 wr last", 18'h7FF, 32'hDEAD_BEEF, 4'hF, 1'b0);
    wr_resp("R7 byte wr", 18'h0, 32'h9999_AB99, 4'b0010, 1'b0);
    rd_ok("R7 rd w0", 18'h0, 32'h1234_AB78);
    rd_ok("R7 rd last", 18'h7FF, 32'hDEAD_BEEF);
    @(negedge clk); im_en = 1; im_addr = 11'h7FF;
    @(posedge clk); #1;
    chk("R7 cop read", im_data, 32'hDEAD_BEEF);
    @(negedge clk); im_en = 0;
  endtask

  task automatic t_ctrl_r8();
    rd_ok("R8 ctrl reset", A_CTRL, 32'h1);
    wr_resp("R8 release", A_CTRL, 32'h0, 4'hF, 1'b0);
    chk("R8 cop_rst low", {31'b0, cop_rst}, 32'h0);
    rd_ok("R8 ctrl readback", A_CTRL, 32'h0);
    wr_resp("R8 hold", A_CTRL, 32'h1, 4'hF, 1'b0);
    chk("R8 cop_rst high", {31'b0, cop_rst}, 32'h1);
  endtask

  task automatic t_sig_r9();
    rd_ok("R9 signature", A_SIG, 32'hF041_011B);
    wr_resp("R9 sig write", A_SIG, 32'h0, 4'hF, 1'b1);
    rd_ok("R9 sig unchanged", A_SIG, 32'hF041_011B);
  endtask

  task automatic t_unmapped_r10();
    logic k, e; logic [31:0] q;
    wb_op(1'b0, 18'h800, '0, 4'hF, k, e, q);
    chk("R10 past mem err", {31'b0, e}, 32'h1);
    chk("R10 past mem data", q, 32'h0);
    wb_op(1'b0, 18'h10004, '0, 4'hF, k, e, q);
    chk("R10 hole err", {30'b0, k, e}, 32'h1);
    chk("R10 hole data", q, 32'h0);
    wr_resp("R10 write status", A_STAT, 32'h5, 4'hF, 1'b1);
    wb_op(1'b0, A_TXD, '0, 4'hF, k, e, q);
    chk("R10 read txd err", {30'b0, k, e}, 32'h1);
    wr_resp("R10 write hole", 18'h20000, 32'h1, 4'hF, 1'b1);
  endtask

  task automatic t_collision_r11();
    wr_resp("R11 prefill", 18'h5, 32'h55AA_55AA, 4'hF, 1'b0);
    @(negedge clk);
    im_en = 1; im_addr = 11'h5;
    cyc = 1; stb = 1; we = 1; adr = 18'h5; wdat = 32'hCAFE_F00D; sel = 4'hF;
    #1 chk("R11 stall on collision", {31'b0, stall}, 32'h1);
    @(posedge clk); #1;
    chk("R11 no ack while stalled", {31'b0, ack}, 32'h0);
    chk("R11 cop served old word", im_data, 32'h55AA_55AA);
    @(negedge clk); im_en = 0;
    #1 chk("R11 stall released", {31'b0, stall}, 32'h0);
    @(posedge clk); #1;
    chk("R11 host completes", {31'b0, ack}, 32'h1);
    @(negedge clk); cyc = 0; stb = 0; we = 0;
    rd_ok("R11 host write landed", 18'h5, 32'hCAFE_F00D);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_host_to_cop_r2();
    t_cop_to_host_r3();
    t_full_r5();
    t_mem_r7();
    t_ctrl_r8();
    t_sig_r9();
    t_unmapped_r10();
    t_collision_r11();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule